// File: doc/BRIEF.md
# Exception Status Stack Unit

This block is the control-register slice of a processor that handles entering and leaving exception handlers. It holds a six-bit status word organised as three two-bit levels. Each level pairs a privilege flag with a global interrupt-enable flag. Alongside it sit a register that holds the resume address and a register that holds the exception code. When the core raises an exception, or an interrupt is admitted, the unit captures the resume address and the code. It shifts a fresh privileged, interrupts-off level into the current slot and, in the same cycle, drives the entry address of the matching handler. A return command shifts the history back by one level.

Handler software reads and rewrites the three registers through a small register port. The port only acts while the current level is privileged. A write attempted from unprivileged state is discarded and flagged on a dedicated output.

The block carries no data stream. Every pin is a plain level or single-cycle pulse sampled on the rising clock edge, so no valid/ready handshake applies.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, the status word is 0x2A: every level is privileged with interrupts disabled. No exception is signalled and no violation is flagged.
- R2: In the cycle after an exception is taken, the resume-address register holds `resume_pc` and the code register holds `exc_code`. For an admitted interrupt, the code register holds the interrupt code instead, which is 0 by default.
- R3: Status layout: bit 1 is the current privilege flag (1 = privileged) and bit 0 is the current interrupt-enable flag. Bits 3:2 hold the previous level and bits 5:4 the oldest level. Taking an exception loads the word with {bits 3:2, bits 1:0, 2'b10}, so the oldest level is discarded.
- R4: `exc_taken` and `next_pc` respond combinationally in the cycle of the request. The class selects the handler: class 0 selects the reset entry, class 2 the alternate entry, and classes 1 and 3 the general entry.
- R5: A return command loads the status word with {bits 5:4, bits 5:4, bits 3:2}, so the oldest level keeps its own value.
- R6: Within one cycle, exception entry has priority over a return, and a return has priority over a register write. When `exc_req` and an admitted interrupt coincide, the code register takes `exc_code`.
- R7: Register addresses are 0 for the status word (bits 5:0), 1 for the code (bits 4:0) and 2 for the resume address. All three are readable combinationally and writable while privileged. Address 3 reads as zero and ignores writes.
- R8: While the current level is unprivileged, writes change no register and `priv_violation` is high in the same cycle, and reads return zero.
- R9: `irq_req` causes an exception only when the current interrupt-enable flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_class | input | 2 | Handler class of the exception |
| exc_code | input | 5 | Code recorded for the exception |
| resume_pc | input | 32 | Address at which the interrupted code resumes |
| irq_req | input | 1 | Interrupt request, subject to the current enable flag |
| rfe | input | 1 | Return-from-exception command |
| reg_addr | input | 2 | Register port address |
| reg_we | input | 1 | Register port write strobe |
| reg_wdata | input | 32 | Register port write data |
| reg_rdata | output | 32 | Register port read data |
| priv_violation | output | 1 | Write attempted from unprivileged state |
| exc_taken | output | 1 | Exception entry in this cycle |
| next_pc | output | 32 | Handler entry address, valid with exc_taken |
| status_o | output | 6 | Status stack word |
| cur_priv | output | 1 | Current privilege flag |
| cur_ie | output | 1 | Current interrupt-enable flag |

## Verification
The assertions assume that every input is a known value from the first clock after reset. They also assume that `exc_req`, `irq_req`, `rfe` and `reg_we` are sampled only at rising edges, so a request lasts exactly the cycles in which it is high. The stimulus changes inputs only at falling edges and drops each command back to zero after one cycle. Collisions between entry, return and write are raised only on purpose, in the priority checks, so every other step has one unambiguous expected status.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int LEVEL_W = 2;
  localparam int LEVELS  = 3;
  localparam int STAT_W  = LEVEL_W * LEVELS;
  localparam int CODE_W  = 5;

  // privileged, interrupts disabled
  localparam logic [LEVEL_W-1:0] LVL_ENTRY = 2'b10;

  typedef enum logic [1:0] {
    CLS_RESET   = 2'd0,
    CLS_GENERAL = 2'd1,
    CLS_ALT     = 2'd2,
    CLS_SPARE   = 2'd3
  } exc_class_e;

  typedef enum logic [1:0] {
    RA_STATUS = 2'd0,
    RA_CAUSE  = 2'd1,
    RA_EPC    = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/exc_status_stack.sv
module exc_status_stack
  import exc_pkg::*;
#(
  parameter int NLEV = LEVELS,
  localparam int SW  = LEVEL_W * NLEV
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_data,
  output logic [SW-1:0] status
);
  logic [SW-1:0] st_q, st_d, push_v, pop_v;

  // level 0 is current, level NLEV-1 is oldest
  for (genvar g = 0; g < NLEV; g++) begin : g_lvl
    if (g == 0) begin : g_cur
      assign push_v[LEVEL_W-1:0] = LVL_ENTRY;
    end else begin : g_shift_in
      assign push_v[g*LEVEL_W +: LEVEL_W] = st_q[(g-1)*LEVEL_W +: LEVEL_W];
    end
    if (g == NLEV-1) begin : g_oldest
      assign pop_v[g*LEVEL_W +: LEVEL_W] = st_q[g*LEVEL_W +: LEVEL_W];
    end else begin : g_shift_out
      assign pop_v[g*LEVEL_W +: LEVEL_W] = st_q[(g+1)*LEVEL_W +: LEVEL_W];
    end
  end

  always_comb begin
    if (push)       st_d = push_v;
    else if (pop)   st_d = pop_v;
    else if (wr_en) st_d = wr_data;
    else            st_d = st_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= {NLEV{LVL_ENTRY}};
    else        st_q <= st_d;
  end

  assign status = st_q;

  AST_PUSH_ENTRY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> status[LEVEL_W-1:0] == LVL_ENTRY); // R3
  AST_PUSH_SHIFTS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> status[SW-1:LEVEL_W] == $past(status[SW-LEVEL_W-1:0])); // R3
  AST_POP_SHIFTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> status[SW-LEVEL_W-1:0] == $past(status[SW-1:LEVEL_W])); // R5
  AST_POP_OLDEST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> status[SW-1:SW-LEVEL_W] == $past(status[SW-1:SW-LEVEL_W])); // R5
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter int            AW      = 32,
  parameter logic [AW-1:0] VEC_RST = 32'h0000_1000,
  parameter logic [AW-1:0] VEC_GEN = 32'h0000_2080,
  parameter logic [AW-1:0] VEC_ALT = 32'h0000_2000
) (
  input  exc_class_e    cls,
  output logic [AW-1:0] handler_pc
);
  always_comb begin
    unique case (cls)
      CLS_RESET: handler_pc = VEC_RST;
      CLS_ALT:   handler_pc = VEC_ALT;
      default:   handler_pc = VEC_GEN;
    endcase
  end
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_pkg::*;
#(
  parameter int                AW       = 32,
  parameter logic [CODE_W-1:0] IRQ_CODE = '0,
  parameter logic [AW-1:0]     VEC_RST  = 32'h0000_1000,
  parameter logic [AW-1:0]     VEC_GEN  = 32'h0000_2080,
  parameter logic [AW-1:0]     VEC_ALT  = 32'h0000_2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [1:0]        exc_class,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [AW-1:0]     resume_pc,
  input  logic              irq_req,
  input  logic              rfe,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_wdata,
  output logic [AW-1:0]     reg_rdata,
  output logic              priv_violation,
  output logic              exc_taken,
  output logic [AW-1:0]     next_pc,
  output logic [STAT_W-1:0] status_o,
  output logic              cur_priv,
  output logic              cur_ie
);
  logic              irq_admit, take, pop, wr_ok;
  logic              wr_status;
  exc_class_e        cls_eff;
  reg_addr_e         ra;
  logic [CODE_W-1:0] code_eff, cause_q;
  logic [AW-1:0]     epc_q;

  assign ra        = reg_addr_e'(reg_addr);
  assign irq_admit = irq_req & cur_ie;
  assign take      = exc_req | irq_admit;
  assign pop       = rfe & ~take;
  assign cls_eff   = exc_req ? exc_class_e'(exc_class) : CLS_GENERAL;
  assign code_eff  = exc_req ? exc_code : IRQ_CODE;
  assign wr_ok     = reg_we & cur_priv & ~take & ~rfe;
  assign wr_status = wr_ok & (ra == RA_STATUS);

  exc_status_stack #(.NLEV(LEVELS)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (take),
    .pop     (pop),
    .wr_en   (wr_status),
    .wr_data (reg_wdata[STAT_W-1:0]),
    .status  (status_o)
  );

  exc_vector_sel #(
    .AW(AW), .VEC_RST(VEC_RST), .VEC_GEN(VEC_GEN), .VEC_ALT(VEC_ALT)
  ) u_vec (
    .cls        (cls_eff),
    .handler_pc (next_pc)
  );

  assign cur_priv       = status_o[1];
  assign cur_ie         = status_o[0];
  assign exc_taken      = take;
  assign priv_violation = reg_we & ~cur_priv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (take) begin
      epc_q   <= resume_pc;
      cause_q <= code_eff;
    end else if (wr_ok) begin
      if (ra == RA_EPC)   epc_q   <= reg_wdata;
      if (ra == RA_CAUSE) cause_q <= reg_wdata[CODE_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (cur_priv) begin
      unique case (ra)
        RA_STATUS: reg_rdata = AW'(status_o);
        RA_CAUSE:  reg_rdata = AW'(cause_q);
        RA_EPC:    reg_rdata = epc_q;
        default:   reg_rdata = '0;
      endcase
    end
  end

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> epc_q == $past(resume_pc)); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !cur_ie && !exc_req) |-> !exc_taken); // R9
  AST_UNPRIV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !cur_priv && !exc_taken && !rfe) |=>
      ($stable(status_o) && $stable(cause_q) && $stable(epc_q))); // R8
  AST_ENTRY_WINS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && rfe) |=> status_o[1:0] == 2'b10); // R6
endmodule

// File: tb/exc_ctrl_unit_tb.sv
`timescale 1ns/1ps
module exc_ctrl_unit_tb;
  localparam logic [31:0] V_RST = 32'h0000_1000;
  localparam logic [31:0] V_GEN = 32'h0000_2080;
  localparam logic [31:0] V_ALT = 32'h0000_2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic exc_req, irq_req, rfe, reg_we;
  logic [1:0] exc_class, reg_addr;
  logic [4:0] exc_code;
  logic [31:0] resume_pc, reg_wdata, reg_rdata, next_pc;
  logic priv_violation, exc_taken, cur_priv, cur_ie;
  logic [5:0] status_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_ctrl_unit u_dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_class(exc_class),
    .exc_code(exc_code), .resume_pc(resume_pc), .irq_req(irq_req), .rfe(rfe),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .priv_violation(priv_violation),
    .exc_taken(exc_taken), .next_pc(next_pc), .status_o(status_o),
    .cur_priv(cur_priv), .cur_ie(cur_ie)
  );

  // op[12:11] 0 idle 1 exc 2 irq 3 rfe | cls[10:9] | taken[8] | pc sel[7:6] | status[5:0]
  localparam int NV = 10;
  localparam logic [12:0] VEC [NV] = '{
    {2'd2, 2'd0, 1'b1, 2'd1, 6'b001110},
    {2'd2, 2'd0, 1'b0, 2'd0, 6'b001110},
    {2'd1, 2'd2, 1'b1, 2'd2, 6'b111010},
    {2'd3, 2'd0, 1'b0, 2'd0, 6'b111110},
    {2'd3, 2'd0, 1'b0, 2'd0, 6'b111111},
    {2'd1, 2'd0, 1'b1, 2'd0, 6'b111110},
    {2'd1, 2'd3, 1'b1, 2'd1, 6'b111010},
    {2'd0, 2'd0, 1'b0, 2'd0, 6'b111010},
    {2'd3, 2'd0, 1'b0, 2'd0, 6'b111110},
    {2'd3, 2'd0, 1'b0, 2'd0, 6'b111111}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr();
    exc_req = 0; irq_req = 0; rfe = 0; reg_we = 0;
    exc_class = 0; reg_addr = 0; exc_code = 0; resume_pc = 0; reg_wdata = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); clr();
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
    @(negedge clk); clr();
  endtask

  function automatic logic [31:0] vsel(input logic [1:0] s);
    return (s == 2'd0) ? V_RST : (s == 2'd2) ? V_ALT : V_GEN;
  endfunction

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset status", {26'b0, status_o}, 32'h2A);
    chk("R1 no exception", {31'b0, exc_taken}, 0);
    chk("R1 no violation", {31'b0, priv_violation}, 0);
    @(negedge clk);
    rd("R7 status read", 2'd0, 32'h2A);

    wr(2'd0, 32'h3);
    chk("R7 status write", {26'b0, status_o}, 32'h3);
    rd("R7 addr3 reads zero", 2'd3, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      v = VEC[i];
      exc_req = (v[12:11] == 2'd1);
      irq_req = (v[12:11] == 2'd2);
      rfe     = (v[12:11] == 2'd3);
      exc_class = v[10:9];
      resume_pc = 32'h100 + 32'(i);
      #1;
      chk($sformatf("R4 R9 taken step %0d", i), {31'b0, exc_taken}, {31'b0, v[8]});
      if (v[8]) chk($sformatf("R4 handler step %0d", i), next_pc, vsel(v[7:6]));
      @(negedge clk); clr();
      chk($sformatf("R3 R5 status step %0d", i), {26'b0, status_o}, {26'b0, v[5:0]});
    end

    // R2: capture of resume address and code
    exc_req = 1; exc_class = 2'd1; exc_code = 5'd13; resume_pc = 32'hDEAD_BEE0;
    @(negedge clk); clr();
    rd("R2 epc captured", 2'd2, 32'hDEAD_BEE0);
    rd("R2 code captured", 2'd1, 32'd13);
    wr(2'd0, 32'h3);
    irq_req = 1;
    @(negedge clk); clr();
    rd("R2 interrupt code", 2'd1, 32'd0);

    // R7: write cause and epc, ignore addr 3
    wr(2'd1, 32'h15);
    rd("R7 cause write", 2'd1, 32'h15);
    wr(2'd2, 32'h0000_4444);
    rd("R7 epc write", 2'd2, 32'h0000_4444);
    wr(2'd3, 32'hFFFF_FFFF);
    rd("R7 addr3 write ignored", 2'd1, 32'h15);

    // R6: entry beats return and write; exc_req beats interrupt code
    wr(2'd0, 32'h3);
    exc_req = 1; irq_req = 1; rfe = 1; exc_code = 5'd7; exc_class = 2'd1;
    reg_we = 1; reg_addr = 2'd0; reg_wdata = 32'h3F;
    @(negedge clk); clr();
    chk("R6 entry wins", {26'b0, status_o}, 32'b001110);
    rd("R6 exc code wins", 2'd1, 32'd7);
    rfe = 1; reg_we = 1; reg_addr = 2'd0; reg_wdata = 32'h0;
    @(negedge clk); clr();
    chk("R6 return wins over write", {26'b0, status_o}, 32'b000011);

    // R8: unprivileged access
    wr(2'd0, 32'h1);
    chk("R8 now unprivileged", {31'b0, cur_priv}, 0);
    reg_we = 1; reg_addr = 2'd0; reg_wdata = 32'h2A; #1;
    chk("R8 violation flag", {31'b0, priv_violation}, 1);
    @(negedge clk); clr();
    chk("R8 status unchanged", {26'b0, status_o}, 32'h1);
    reg_we = 1; reg_addr = 2'd1; reg_wdata = 32'h1F;
    @(negedge clk); clr();
    rd("R8 read zero", 2'd2, 0);
    exc_req = 1; exc_class = 2'd1; exc_code = 5'd2; resume_pc = 32'h88;
    @(negedge clk); clr();
    chk("R3 push from user", {26'b0, status_o}, 32'b000110);
    rd("R8 cause holds exc code", 2'd1, 32'd2);
    reg_we = 1; reg_addr = 2'd3; #1;
    chk("R8 no violation privileged", {31'b0, priv_violation}, 0);
    @(negedge clk); clr();

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule